// File: doc/BRIEF.md
# PCM Highway Time-Slot Transmitter

This block places one voice channel's transmit sample onto a shared time-division PCM highway. A frame sync pulse marks the start of each frame. The channel owns a programmable slot number S. The sample goes out MSB first in slot S. In two of the formats it continues into slot S+1.

Three formats are available:
- **Companded**: an 8-bit companded byte in slot S. When A-law is selected, the byte is XORed with 8'h55 before it is sent.
- **Linear**: a 16-bit two's-complement sample spread over slots S and S+1.
- **Signaling**: the companded byte in slot S, followed by a status byte in slot S+1 built from the detector and fail inputs.

A half-rate option holds each bit for two highway clocks. Only the slot timing is affected by this option; the way the sample is captured does not change. Configuration, sample and status are all captured when frame sync is seen. Changes that arrive during a frame therefore take effect at the next frame.

The sequencer has four named states:
- `ST_IDLE`: nothing driven.
- `ST_LEAD`: counting the slots that come before S.
- `ST_FIRST`: sending slot S.
- `ST_SECOND`: sending slot S+1.

The named transitions are:
- **sync-load**: from any state, to `ST_FIRST` when S = 0, otherwise to `ST_LEAD`.
- **slot-reached**: from `ST_LEAD` to `ST_FIRST` at the end of slot S-1.
- **first-done**: from `ST_FIRST` to `ST_SECOND` in the linear and signaling formats, or to `ST_IDLE` in the companded format.
- **second-done**: from `ST_SECOND` to `ST_IDLE`.

Top module: `pcm_slot_tx`

## Requirements
- R1: Bit period 0 of slot 0 is the first clock after the clock edge at which `fsync` is sampled high. Each slot is 8 bit periods long and is sent MSB first. Slot S covers bit periods 8S to 8S+7.
- R2: When `half_rate` = 1 is captured, each bit period lasts two highway clocks, and `dout`/`drive_en` hold steady across both clocks. When it is 0, each bit period lasts one clock.
- R3: Format 2'b00 (companded; 2'b11 behaves the same) sends `sample[7:0]` in slot S only. When `alaw` = 1, the byte is XORed with 8'h55 first.
- R4: Format 2'b01 (linear) sends `sample[15:8]` in slot S and `sample[7:0]` in slot S+1, sign bit first, with no inversion.
- R5: Format 2'b10 (signaling) sends the companded byte of R3 in slot S. Slot S+1 carries the byte {det_hook, det_aux, 3'b000, fail_flag, 2'b00}. Its bit 7 follows bit 0 of the data byte directly.
- R6: With `chan_en` = 0, data slots are not driven. The signaling slot of format 2'b10 is still driven.
- R7: `drive_en` is high only during bit periods of driven owned slots. `dout` is 0 whenever `drive_en` is 0.
- R8: `slot_sel`, `fmt`, `alaw`, `half_rate`, `chan_en`, `sample` and the status inputs are captured at frame sync. Changes between syncs do not affect the frame in progress.
- R9: After reset, and until the first frame sync, `drive_en` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Highway clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsync | input | 1 | Frame sync, sampled high for one clock |
| slot_sel | input | SLOT_W | Owned slot number S |
| fmt | input | 2 | Format: 00 companded, 01 linear, 10 signaling |
| alaw | input | 1 | Apply A-law alternate bit inversion to the companded byte |
| half_rate | input | 1 | One bit per two clocks |
| chan_en | input | 1 | Channel enable for data slots |
| sample | input | 16 | Transmit sample (companded byte in bits 7:0) |
| det_hook | input | 1 | Debounced hook detector status |
| det_aux | input | 1 | Second detector status |
| fail_flag | input | 1 | Fail status |
| dout | output | 1 | Serial highway data |
| drive_en | output | 1 | High while the highway is driven |

## Verification
The hardest case to reach is a frame whose inputs have all changed while the frame is still in progress. Only that case shows whether the captured configuration and sample really govern the whole frame, in both bit-rate modes. In every swept frame, the bench inverts each configuration and data input on the clock right after the sync. It does this across all formats, both rates, both enables and slot numbers up to the top of the range. For every clock of the frame, it predicts `drive_en` and `dout` arithmetically from the values captured before the change.

// File: rtl/pcm_tx_pkg.sv
`timescale 1ns/1ps
package pcm_tx_pkg;

    localparam int SLOT_BITS = 8;
    localparam int WORD_W    = 16;

    typedef enum logic [1:0] {
        FMT_COMP   = 2'b00,
        FMT_LINEAR = 2'b01,
        FMT_SIGNAL = 2'b10,
        FMT_COMP_X = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_FIRST  = 2'd2,
        ST_SECOND = 2'd3
    } seq_state_e;

    localparam logic [7:0] ALAW_MASK = 8'h55;

    function automatic logic uses_second(input fmt_e f);
        return (f == FMT_LINEAR) || (f == FMT_SIGNAL);
    endfunction

endpackage

// File: rtl/pcm_bit_timer.sv
`timescale 1ns/1ps
module pcm_bit_timer (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    input  logic half_rate,
    output logic bit_end,
    output logic half_q
);

    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            half_q  <= 1'b0;
        end else if (fsync) begin
            phase_q <= 1'b0;
            half_q  <= half_rate;
        end else if (half_q) begin
            phase_q <= ~phase_q;
        end else begin
            phase_q <= 1'b0;
        end
    end

    assign bit_end = !half_q || phase_q;

    AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> !phase_q); // R1

endmodule

// File: rtl/pcm_word_build.sv
`timescale 1ns/1ps
module pcm_word_build
    import pcm_tx_pkg::*;
(
    input  fmt_e                fmt,
    input  logic                alaw,
    input  logic [WORD_W-1:0]   sample,
    input  logic                det_hook,
    input  logic                det_aux,
    input  logic                fail_flag,
    output logic [WORD_W-1:0]   word
);

    localparam int HALF = WORD_W / 2;

    logic [HALF-1:0] comp_byte;
    logic [HALF-1:0] sig_byte;

    always_comb begin
        comp_byte = sample[HALF-1:0] ^ (alaw ? ALAW_MASK : '0);
        sig_byte  = '0;
        sig_byte[7] = det_hook;
        sig_byte[6] = det_aux;
        sig_byte[2] = fail_flag;
        unique case (fmt)
            FMT_LINEAR: word = sample;
            FMT_SIGNAL: word = {comp_byte, sig_byte};
            default:    word = {comp_byte, {HALF{1'b0}}};
        endcase
    end

endmodule

// File: rtl/pcm_slot_seq.sv
`timescale 1ns/1ps
module pcm_slot_seq
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fsync,
    input  logic                bit_end,
    input  logic                half_q,
    input  logic [SLOT_W-1:0]   slot_sel,
    input  fmt_e                fmt,
    input  logic                chan_en,
    input  logic [WORD_W-1:0]   word,
    output logic                dout,
    output logic                drive_en
);

    localparam int CNT_W = SLOT_W + 1;
    localparam int BIT_W = $clog2(SLOT_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    seq_state_e          state_q, state_d;
    logic [SLOT_W-1:0]   slot_q;
    fmt_e                fmt_q;
    logic                en_q;
    logic [CNT_W-1:0]    slot_cnt_q, slot_cnt_d;
    logic [BIT_W-1:0]    bit_cnt_q;
    logic [WORD_W-1:0]   shreg_q;
    logic                last_bit;

    assign last_bit = (bit_cnt_q == LAST_BIT);

    // next-state decision
    always_comb begin
        state_d    = state_q;
        slot_cnt_d = slot_cnt_q;
        if (fsync) begin
            slot_cnt_d = '0;
            state_d    = (slot_sel == '0) ? ST_FIRST : ST_LEAD;
        end else if (bit_end && last_bit) begin
            unique case (state_q)
                ST_IDLE:   state_d = ST_IDLE;
                ST_LEAD: begin
                    slot_cnt_d = slot_cnt_q + 1'b1;
                    if (slot_cnt_d == {1'b0, slot_q})
                        state_d = ST_FIRST;
                end
                ST_FIRST:  state_d = uses_second(fmt_q) ? ST_SECOND : ST_IDLE;
                ST_SECOND: state_d = ST_IDLE;
            endcase
        end
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            slot_q     <= '0;
            fmt_q      <= FMT_COMP;
            en_q       <= 1'b0;
            slot_cnt_q <= '0;
            bit_cnt_q  <= '0;
            shreg_q    <= '0;
        end else begin
            state_q    <= state_d;
            slot_cnt_q <= slot_cnt_d;
            if (fsync) begin
                slot_q    <= slot_sel;
                fmt_q     <= fmt;
                en_q      <= chan_en;
                bit_cnt_q <= '0;
                shreg_q   <= word;
            end else if (bit_end) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                if (state_q == ST_FIRST || state_q == ST_SECOND)
                    shreg_q <= {shreg_q[WORD_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        drive_en = 1'b0;
        unique case (state_q)
            ST_FIRST:  drive_en = en_q;
            ST_SECOND: drive_en = en_q || (fmt_q == FMT_SIGNAL);
            default:   drive_en = 1'b0;
        endcase
        dout = drive_en & shreg_q[WORD_W-1];
    end

    AST_HALF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (half_q && !bit_end && !fsync) |=> ($stable(dout) && $stable(drive_en))); // R2
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !fsync |=> ($stable(slot_q) && $stable(fmt_q) && $stable(en_q))); // R8
    AST_NO_SECOND_COMP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND) |-> uses_second(fmt_q)); // R3
    AST_SIG_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SECOND && fmt_q == FMT_SIGNAL) |-> drive_en); // R6
    AST_SYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync && slot_sel != '0) |=> (state_q == ST_LEAD && !drive_en)); // R1

endmodule

// File: rtl/pcm_slot_tx.sv
`timescale 1ns/1ps
module pcm_slot_tx
    import pcm_tx_pkg::*;
#(
    parameter int SLOT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic [SLOT_W-1:0] slot_sel,
    input  logic [1:0]        fmt,
    input  logic              alaw,
    input  logic              half_rate,
    input  logic              chan_en,
    input  logic [15:0]       sample,
    input  logic              det_hook,
    input  logic              det_aux,
    input  logic              fail_flag,
    output logic              dout,
    output logic              drive_en
);

    logic              bit_end;
    logic              half_q;
    logic [WORD_W-1:0] word;
    fmt_e              fmt_in;

    assign fmt_in = fmt_e'(fmt);

    pcm_bit_timer u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .half_rate (half_rate),
        .bit_end   (bit_end),
        .half_q    (half_q)
    );

    pcm_word_build u_build (
        .fmt       (fmt_in),
        .alaw      (alaw),
        .sample    (sample),
        .det_hook  (det_hook),
        .det_aux   (det_aux),
        .fail_flag (fail_flag),
        .word      (word)
    );

    pcm_slot_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsync    (fsync),
        .bit_end  (bit_end),
        .half_q   (half_q),
        .slot_sel (slot_sel),
        .fmt      (fmt_in),
        .chan_en  (chan_en),
        .word     (word),
        .dout     (dout),
        .drive_en (drive_en)
    );

    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_en |-> !dout); // R7

endmodule

// File: tb/sim_pcm_slot_tx.sv
`timescale 1ns/1ps
module sim_pcm_slot_tx;

    localparam int SLOT_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fsync = 1'b0;
    logic [SLOT_W-1:0] slot_sel = '0;
    logic [1:0]        fmt = 2'b00;
    logic              alaw = 1'b0;
    logic              half_rate = 1'b0;
    logic              chan_en = 1'b0;
    logic [15:0]       sample = '0;
    logic              det_hook = 1'b0;
    logic              det_aux = 1'b0;
    logic              fail_flag = 1'b0;
    logic              dout;
    logic              drive_en;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pcm_slot_tx #(.SLOT_W(SLOT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .slot_sel(slot_sel),
        .fmt(fmt), .alaw(alaw), .half_rate(half_rate), .chan_en(chan_en),
        .sample(sample), .det_hook(det_hook), .det_aux(det_aux),
        .fail_flag(fail_flag), .dout(dout), .drive_en(drive_en)
    );

    task automatic check(input string tag, input int k, input logic [1:0] act, input logic [1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual drive/dout=%b expected=%b", tag, k, act, exp);
        end
    endtask

    // One frame: capture config at sync, then invert every input (R8) and
    // predict each clock from the captured values (R1, R2).
    task automatic run_frame(input int slot, input int f, input bit al, input bit hr,
                             input bit en, input logic [15:0] smp, input logic [2:0] st);
        logic [15:0] w;
        logic [7:0]  cb;
        int          n;
        @(negedge clk);
        slot_sel = slot[SLOT_W-1:0]; fmt = f[1:0]; alaw = al; half_rate = hr;
        chan_en = en; sample = smp; {det_hook, det_aux, fail_flag} = st;
        fsync = 1'b1;
        cb = smp[7:0] ^ (al ? 8'h55 : 8'h00);
        if (f == 1)      w = smp;                                         // R4
        else if (f == 2) w = {cb, st[2], st[1], 3'b000, st[0], 2'b00};    // R5
        else             w = {cb, 8'h00};                                 // R3
        n = (slot + 3) * 8 * (hr ? 2 : 1);
        @(posedge clk);
        @(negedge clk);
        fsync = 1'b0;
        slot_sel = ~slot_sel; fmt = (f == 2) ? 2'b01 : 2'b10; alaw = ~al;
        half_rate = ~hr; chan_en = ~en; sample = ~smp;
        {det_hook, det_aux, fail_flag} = ~st;
        for (int k = 0; k < n; k++) begin
            int   b;
            int   s;
            int   p;
            logic drv;
            logic bt;
            string tag;
            b = hr ? k / 2 : k;
            s = b / 8;
            p = b % 8;
            drv = 1'b0; bt = 1'b0;
            tag = hr ? "R2/R7/R8" : "R1/R7/R8";
            if (s == slot) begin
                drv = en; bt = w[15 - p];
                tag = !en ? "R6/R8" : (f == 1) ? "R4/R1/R8" : (f == 2) ? "R5/R1/R8" : "R3/R1/R8";
            end else if (s == slot + 1 && f != 0) begin
                drv = en || (f == 2); bt = w[7 - p];
                tag = (f == 2) ? (en ? "R5/R8" : "R6/R5/R8") : (en ? "R4/R8" : "R6/R4/R8");
            end
            check(tag, k, {drive_en, dout}, {drv, drv & bt});
            @(negedge clk);
        end
    endtask

    initial begin
        int slots[4] = '{0, 1, 4, 31};
        logic [15:0] smp;
        repeat (3) @(negedge clk);
        check("R9", 0, {drive_en, dout}, 2'b00);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            sample = 16'hFFFF; chan_en = 1'b1;
            @(negedge clk);
            check("R9", i, {drive_en, dout}, 2'b00);
        end
        smp = 16'hA5C3;
        foreach (slots[si]) begin
            for (int f = 0; f < 3; f++) begin
                for (int m = 0; m < 8; m++) begin
                    smp = {smp[14:0], smp[15] ^ smp[13] ^ smp[12] ^ smp[10]};
                    run_frame(slots[si], f, m[0], m[1], m[2], smp, smp[2:0] ^ 3'(m));
                end
            end
        end
        run_frame(2, 1, 1'b0, 1'b0, 1'b1, 16'h8001, 3'b000); // R4 sign bit first
        run_frame(3, 2, 1'b1, 1'b1, 1'b0, 16'h00FF, 3'b101); // R6 signaling while disabled
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule